// File: doc/BRIEF.md
# Double-Column Hit Drain Buffer

This block sits in the periphery of one double column of 160 pixel cells. Each cell keeps a hit flag and an 8-bit amplitude. When any flag in the column is set, the block opens an event. It captures the bunch-crossing count at that moment and then moves the flagged pixels, lowest index first and one per clock, into a hit store. A separate timestamp store keeps one entry per event. The first hit of each event carries a start marker in the hit store, and that marker is what ties the hits to their timestamp.

A trigger input arrives a fixed number of crossings after the collision it selects. The block compares the oldest timestamp with the trigger crossing minus that latency. On a match, it streams the event's hits out through a valid/ready port and flags the last hit. Events that are too old are thrown away, both when a trigger arrives and on their own when no trigger claims them. When a store has no room, the new data is dropped and a loss counter goes up.

Top module: `dcol_drain_buf`

## Requirements
- R1: After reset, `rd_valid_o` is 0 and both loss counters read 0.
- R2: A hit on a pixel whose flag is already set is ignored. The pixel keeps its first amplitude and yields only one hit until it has been drained.
- R3: An event starts on the first clock edge at which a flag is set while no drain is running. Its timestamp is `bx_i` at that edge. Its pixels are drained one per clock in ascending index order, and only the first stored hit carries the start marker.
- R4: Hits that set flags while an event is draining are not part of that event. They form the next event, with its own timestamp, even when their pixel index is lower.
- R5: If the trigger crossing minus the timestamp of the oldest event (modulo 2^BX_W) equals LATENCY, that event's hits appear on the read port in ascending pixel order. Each beat shows the pixel index in `rd_pix_o` and the amplitude in `rd_amp_o`. `rd_eoe_o` is 1 on the last beat only. While `rd_valid_o` is 1 and `rd_ready_i` is 0, all read outputs hold.
- R6: A trigger whose age for the oldest event is smaller than LATENCY produces no output and keeps the event.
- R7: A trigger whose age for the oldest event is larger than LATENCY discards that event with all its hits. The next event is then compared against the same trigger.
- R8: With no trigger, an event whose age against the current `bx_i` exceeds LATENCY is discarded, so a later trigger cannot read it.
- R9: If the timestamp store (TS_DEPTH entries) or the hit store (DATA_DEPTH entries) is full when an event's first hit is drained, the whole event is dropped and `evt_lost_cnt_o` rises by one.
- R10: A later hit of a stored event that finds the hit store full is dropped and raises `hit_lost_cnt_o` by one. The rest of the event stays readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bx_i | input | BX_W | Current bunch-crossing count |
| hit_i | input | 160 | Per-pixel hit strobe |
| amp_i | input | 160*8 | Per-pixel amplitude, pixel p at bits [8p+7:8p] |
| trig_i | input | 1 | Trigger strobe for crossing `bx_i` |
| rd_ready_i | input | 1 | Read port ready |
| rd_valid_o | output | 1 | Read port valid |
| rd_pix_o | output | 8 | Pixel index of the current hit |
| rd_amp_o | output | 8 | Amplitude of the current hit |
| rd_eoe_o | output | 1 | Last hit of the event |
| evt_lost_cnt_o | output | CNT_W | Events dropped for lack of room (saturating) |
| hit_lost_cnt_o | output | CNT_W | Single hits dropped for lack of room (saturating) |

## Verification
The hardest states to reach are the full stores, because events normally age out and free space. The bench therefore holds `bx_i` still and never triggers. It stacks twelve one-hit events to fill the timestamp store, and a 33-pixel event to overrun the 32-entry hit store one hit before its end. Event splitting is reached by pulsing a low-index pixel, with the crossing count moved forward, in the middle of a three-hit drain. The read order then shows whether the late hit was wrongly merged into the running event.

// File: rtl/dcol_pkg.sv
`timescale 1ns/1ps
package dcol_pkg;
  localparam int N_PIX = 160;
  localparam int PIX_W = $clog2(N_PIX);
  localparam int AMP_W = 8;

  typedef struct packed {
    logic             marker;
    logic [PIX_W-1:0] pix;
    logic [AMP_W-1:0] amp;
  } hit_t;

  localparam int HIT_W = $bits(hit_t);

  typedef enum logic [1:0] {R_IDLE, R_PURGE, R_SEND} rd_state_e;
endpackage

// File: rtl/dcol_fifo.sv
`timescale 1ns/1ps
module dcol_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 12,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  head_o,
  output logic [W-1:0]  next_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  function automatic logic [PW-1:0] inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign head_o  = mem_q[rd_q];
  assign next_o  = mem_q[inc(rd_q)];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= inc(wr_q);
      if (pop_ok)  rd_q <= inc(rd_q);
      cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_q] <= wdata_i;
  end
endmodule

// File: rtl/dcol_pixel_array.sv
`timescale 1ns/1ps
module dcol_pixel_array
  import dcol_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_PIX-1:0]       hit_i,
  input  logic [N_PIX*AMP_W-1:0] amp_i,
  input  logic                   clr_i,
  input  logic [PIX_W-1:0]       idx_i,
  output logic [N_PIX-1:0]       flags_o,
  output logic [AMP_W-1:0]       amp_o
);
  logic [AMP_W-1:0] amp_q [N_PIX];

  for (genvar p = 0; p < N_PIX; p++) begin : g_cell
    logic clr_me;
    assign clr_me = clr_i && (idx_i == PIX_W'(p));

    // a flagged cell is dead to new hits until drained
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flags_o[p] <= 1'b0;
        amp_q[p]   <= '0;
      end else if (flags_o[p]) begin
        if (clr_me) flags_o[p] <= 1'b0;
      end else if (hit_i[p]) begin
        flags_o[p] <= 1'b1;
        amp_q[p]   <= amp_i[p*AMP_W +: AMP_W];
      end
    end
  end

  assign amp_o = amp_q[idx_i];
endmodule

// File: rtl/dcol_drain.sv
`timescale 1ns/1ps
module dcol_drain
  import dcol_pkg::*;
#(
  parameter int BX_W  = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_PIX-1:0] flags_i,
  input  logic [AMP_W-1:0] amp_i,
  input  logic [BX_W-1:0]  bx_i,
  input  logic             ts_full_i,
  input  logic             data_full_i,
  output logic             clr_o,
  output logic [PIX_W-1:0] idx_o,
  output logic             ts_push_o,
  output logic [BX_W-1:0]  ts_wdata_o,
  output logic             data_push_o,
  output hit_t             data_wdata_o,
  output logic [CNT_W-1:0] evt_lost_o,
  output logic [CNT_W-1:0] hit_lost_o
);
  logic             busy_q, keep_q;
  logic [N_PIX-1:0] pend_q;
  logic [N_PIX-1:0] mask, oh, rest;
  logic             any, first, store_first, store_more, lose_more;
  logic [PIX_W-1:0] idx;

  assign mask = busy_q ? pend_q : flags_i;
  assign any  = |mask;
  assign oh   = mask & (~mask + 1'b1);
  assign rest = mask & ~oh;

  always_comb begin
    idx = '0;
    for (int i = 0; i < N_PIX; i++) begin
      if (oh[i]) idx = PIX_W'(i);
    end
  end

  assign first       = any && !busy_q;
  assign store_first = first && !ts_full_i && !data_full_i;
  assign store_more  = any && busy_q && keep_q && !data_full_i;
  assign lose_more   = any && busy_q && keep_q && data_full_i;

  assign clr_o        = any;
  assign idx_o        = idx;
  assign ts_push_o    = store_first;
  assign ts_wdata_o   = bx_i;
  assign data_push_o  = store_first || store_more;
  assign data_wdata_o = '{marker: first, pix: idx, amp: amp_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      keep_q     <= 1'b0;
      pend_q     <= '0;
      evt_lost_o <= '0;
      hit_lost_o <= '0;
    end else begin
      if (any) begin
        busy_q <= |rest;
        pend_q <= rest;
      end
      if (first) keep_q <= store_first;
      if (first && !store_first && evt_lost_o != '1) evt_lost_o <= evt_lost_o + 1'b1;
      if (lose_more && hit_lost_o != '1) hit_lost_o <= hit_lost_o + 1'b1;
    end
  end
endmodule

// File: rtl/dcol_readout.sv
`timescale 1ns/1ps
module dcol_readout
  import dcol_pkg::*;
#(
  parameter int BX_W    = 8,
  parameter int LATENCY = 136,
  parameter int DCW     = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic [BX_W-1:0]  bx_i,
  input  logic [BX_W-1:0]  ts_head_i,
  input  logic             ts_empty_i,
  output logic             ts_pop_o,
  input  hit_t             data_head_i,
  input  hit_t             data_next_i,
  input  logic [DCW-1:0]   data_count_i,
  input  logic             data_empty_i,
  output logic             data_pop_o,
  input  logic             rd_ready_i,
  output logic             rd_valid_o,
  output logic [PIX_W-1:0] rd_pix_o,
  output logic [AMP_W-1:0] rd_amp_o,
  output logic             rd_eoe_o
);
  localparam logic [BX_W-1:0] LAT = BX_W'(LATENCY);

  rd_state_e       state_q, state_d;
  logic            pend_q, pend_d;
  logic [BX_W-1:0] tbx_q, tbx_d;
  logic [BX_W-1:0] age_trig, age_now;
  logic            last;

  assign age_trig = tbx_q - ts_head_i;
  assign age_now  = bx_i - ts_head_i;
  assign last     = (data_count_i <= DCW'(1)) || data_next_i.marker;

  assign rd_pix_o = data_head_i.pix;
  assign rd_amp_o = data_head_i.amp;
  assign rd_eoe_o = last;

  always_comb begin
    state_d    = state_q;
    pend_d     = pend_q;
    tbx_d      = tbx_q;
    ts_pop_o   = 1'b0;
    data_pop_o = 1'b0;
    rd_valid_o = 1'b0;
    unique case (state_q)
      R_IDLE: begin
        if (pend_q) begin
          if (ts_empty_i) begin
            pend_d = 1'b0;
          end else if (age_trig == LAT) begin
            ts_pop_o = 1'b1;
            state_d  = R_SEND;
          end else if (age_trig > LAT) begin
            ts_pop_o = 1'b1;
            state_d  = R_PURGE;
          end else begin
            pend_d = 1'b0;
          end
        end else if (!ts_empty_i && age_now > LAT) begin
          ts_pop_o = 1'b1;
          state_d  = R_PURGE;
        end
      end
      R_PURGE: begin
        if (data_empty_i) begin
          state_d = R_IDLE;
        end else begin
          data_pop_o = 1'b1;
          if (last) state_d = R_IDLE;
        end
      end
      R_SEND: begin
        rd_valid_o = !data_empty_i;
        if (rd_valid_o && rd_ready_i) begin
          data_pop_o = 1'b1;
          if (last) begin
            state_d = R_IDLE;
            pend_d  = 1'b0;
          end
        end
      end
      default: state_d = R_IDLE;
    endcase
    // one trigger in flight; later strobes wait out
    if (trig_i && !pend_q) begin
      pend_d = 1'b1;
      tbx_d  = bx_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= R_IDLE;
      pend_q  <= 1'b0;
      tbx_q   <= '0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      tbx_q   <= tbx_d;
    end
  end
endmodule

// File: rtl/dcol_drain_buf.sv
`timescale 1ns/1ps
module dcol_drain_buf
  import dcol_pkg::*;
#(
  parameter int BX_W       = 8,
  parameter int LATENCY    = 136,
  parameter int TS_DEPTH   = 12,
  parameter int DATA_DEPTH = 32,
  parameter int CNT_W      = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [BX_W-1:0]        bx_i,
  input  logic [N_PIX-1:0]       hit_i,
  input  logic [N_PIX*AMP_W-1:0] amp_i,
  input  logic                   trig_i,
  input  logic                   rd_ready_i,
  output logic                   rd_valid_o,
  output logic [PIX_W-1:0]       rd_pix_o,
  output logic [AMP_W-1:0]       rd_amp_o,
  output logic                   rd_eoe_o,
  output logic [CNT_W-1:0]       evt_lost_cnt_o,
  output logic [CNT_W-1:0]       hit_lost_cnt_o
);
  localparam int TCW = $clog2(TS_DEPTH + 1);
  localparam int DCW = $clog2(DATA_DEPTH + 1);

  logic [N_PIX-1:0] flags;
  logic [AMP_W-1:0] sel_amp;
  logic             clr;
  logic [PIX_W-1:0] idx;

  logic            ts_push, ts_pop, ts_full, ts_empty;
  logic [BX_W-1:0] ts_wdata, ts_head, ts_next;
  logic [TCW-1:0]  ts_count;

  logic           data_push, data_pop, data_full, data_empty;
  hit_t           data_wdata, data_head, data_next;
  logic [DCW-1:0] data_count;

  dcol_pixel_array u_pix (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (hit_i),
    .amp_i   (amp_i),
    .clr_i   (clr),
    .idx_i   (idx),
    .flags_o (flags),
    .amp_o   (sel_amp)
  );

  dcol_drain #(.BX_W(BX_W), .CNT_W(CNT_W)) u_drain (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flags_i      (flags),
    .amp_i        (sel_amp),
    .bx_i         (bx_i),
    .ts_full_i    (ts_full),
    .data_full_i  (data_full),
    .clr_o        (clr),
    .idx_o        (idx),
    .ts_push_o    (ts_push),
    .ts_wdata_o   (ts_wdata),
    .data_push_o  (data_push),
    .data_wdata_o (data_wdata),
    .evt_lost_o   (evt_lost_cnt_o),
    .hit_lost_o   (hit_lost_cnt_o)
  );

  dcol_fifo #(.W(BX_W), .DEPTH(TS_DEPTH)) u_ts_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (ts_push),
    .wdata_i (ts_wdata),
    .pop_i   (ts_pop),
    .head_o  (ts_head),
    .next_o  (ts_next),
    .count_o (ts_count),
    .full_o  (ts_full),
    .empty_o (ts_empty)
  );

  dcol_fifo #(.W(HIT_W), .DEPTH(DATA_DEPTH)) u_data_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (data_push),
    .wdata_i (data_wdata),
    .pop_i   (data_pop),
    .head_o  (data_head),
    .next_o  (data_next),
    .count_o (data_count),
    .full_o  (data_full),
    .empty_o (data_empty)
  );

  dcol_readout #(.BX_W(BX_W), .LATENCY(LATENCY), .DCW(DCW)) u_rd (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .trig_i       (trig_i),
    .bx_i         (bx_i),
    .ts_head_i    (ts_head),
    .ts_empty_i   (ts_empty),
    .ts_pop_o     (ts_pop),
    .data_head_i  (data_head),
    .data_next_i  (data_next),
    .data_count_i (data_count),
    .data_empty_i (data_empty),
    .data_pop_o   (data_pop),
    .rd_ready_i   (rd_ready_i),
    .rd_valid_o   (rd_valid_o),
    .rd_pix_o     (rd_pix_o),
    .rd_amp_o     (rd_amp_o),
    .rd_eoe_o     (rd_eoe_o)
  );
endmodule

// File: rtl/dcol_drain_buf_chk.sv
`timescale 1ns/1ps
module dcol_drain_buf_chk
  import dcol_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rd_valid_o,
  input logic             rd_ready_i,
  input logic [PIX_W-1:0] rd_pix_o,
  input logic [AMP_W-1:0] rd_amp_o,
  input logic             rd_eoe_o,
  input logic [CNT_W-1:0] evt_lost_cnt_o,
  input logic [CNT_W-1:0] hit_lost_cnt_o,
  input logic             ts_push,
  input logic             ts_full,
  input logic             data_push,
  input logic             data_full,
  input hit_t             data_wdata,
  input logic             data_empty
);
  a_r5_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_pix_o) && $stable(rd_amp_o) && $stable(rd_eoe_o));

  a_r5_valid_has_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> !data_empty);

  a_r3_ts_links_marker: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ts_push |-> data_push && data_wdata.marker);

  a_r9_no_ts_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ts_push |-> !ts_full);

  a_r10_no_data_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_push |-> !data_full);

  a_r9_evt_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (evt_lost_cnt_o == $past(evt_lost_cnt_o)) || (evt_lost_cnt_o == $past(evt_lost_cnt_o) + 1'b1));

  a_r10_hit_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (hit_lost_cnt_o == $past(hit_lost_cnt_o)) || (hit_lost_cnt_o == $past(hit_lost_cnt_o) + 1'b1));
endmodule

bind dcol_drain_buf dcol_drain_buf_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/dcol_drain_buf_bench.sv
`timescale 1ns/1ps
module dcol_drain_buf_bench;
  localparam int NP = 160;
  localparam int LAT = 136;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic [7:0]     bx_i = '0;
  logic [NP-1:0]  hit_i = '0;
  logic [NP*8-1:0] amp_i = '0;
  logic           trig_i = 1'b0;
  logic           rd_ready_i = 1'b1;
  logic           rd_valid_o;
  logic [7:0]     rd_pix_o, rd_amp_o;
  logic           rd_eoe_o;
  logic [15:0]    evt_lost_cnt_o, hit_lost_cnt_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int exp_pix [64];

  always #2.5 clk_i = ~clk_i;

  dcol_drain_buf u_dcol_drain_buf (.*);

  function automatic logic [7:0] amp_of(int p);
    return 8'((p * 3 + 7) & 255);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_pix(int lo, int hi);
    for (int p = lo; p <= hi; p++) hit_i[p] = 1'b1;
    @(negedge clk_i);
    hit_i = '0;
  endtask

  task automatic trigger(logic [7:0] bx);
    bx_i = bx;
    trig_i = 1'b1;
    @(negedge clk_i);
    trig_i = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  // reads n beats, compares with exp_pix, optional stall on first beat
  task automatic read_event(string req, int n, bit stall);
    int got = 0;
    int guard = 0;
    if (stall) begin
      rd_ready_i = 1'b0;
      while (!rd_valid_o && guard < 40) begin @(negedge clk_i); guard++; end
      begin
        logic [7:0] p0 = rd_pix_o;
        idle(3);
        check({req, " stall valid"}, int'(rd_valid_o), 1);
        check({req, " stall pix"}, int'(rd_pix_o), int'(p0));
      end
      rd_ready_i = 1'b1;
    end
    guard = 0;
    while (got < n && guard < 300) begin
      if (rd_valid_o) begin
        check({req, " pix"}, int'(rd_pix_o), exp_pix[got]);
        check({req, " amp"}, int'(rd_amp_o), int'(amp_of(exp_pix[got])));
        check({req, " eoe"}, int'(rd_eoe_o), int'(got == n - 1));
        got++;
      end
      @(negedge clk_i);
      guard++;
    end
    check({req, " beats"}, got, n);
    idle(4);
    check({req, " no trailing beat"}, int'(rd_valid_o), 0);
  endtask

  task automatic expect_silent(string req, int n);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      if (rd_valid_o) seen++;
      @(negedge clk_i);
    end
    check(req, seen, 0);
  endtask

  task automatic t_reset;
    check("R1 valid", int'(rd_valid_o), 0);
    check("R1 evt_lost", int'(evt_lost_cnt_o), 0);
    check("R1 hit_lost", int'(hit_lost_cnt_o), 0);
  endtask

  task automatic t_basic_and_rehit;
    bx_i = 8'd10;
    pulse_pix(0, 9);
    // pixel 9 still flagged: new amplitude must not stick (R2)
    amp_i[9*8 +: 8] = 8'hEE;
    hit_i[9] = 1'b1;
    @(negedge clk_i);
    hit_i = '0;
    amp_i[9*8 +: 8] = amp_of(9);
    idle(20);
    for (int i = 0; i < 10; i++) exp_pix[i] = i;
    trigger(8'(10 + LAT));
    read_event("R5 R2 R3 basic", 10, 1'b1);
    trigger(8'(10 + LAT));
    expect_silent("R2 no second event", 20);
  endtask

  task automatic t_split;
    bx_i = 8'd30;
    for (int p = 20; p <= 22; p++) hit_i[p] = 1'b1;
    @(negedge clk_i);
    hit_i = '0;
    @(negedge clk_i);
    bx_i = 8'd31;
    hit_i[3] = 1'b1;
    @(negedge clk_i);
    hit_i = '0;
    idle(10);
    exp_pix[0] = 20; exp_pix[1] = 21; exp_pix[2] = 22;
    trigger(8'(30 + LAT));
    read_event("R4 first event", 3, 1'b0);
    exp_pix[0] = 3;
    trigger(8'(31 + LAT));
    read_event("R4 R3 late event ts", 1, 1'b0);
  endtask

  task automatic t_young;
    bx_i = 8'd50;
    pulse_pix(77, 77);
    idle(5);
    trigger(8'(50 + LAT - 1));
    expect_silent("R6 young trigger", 15);
    exp_pix[0] = 77;
    trigger(8'(50 + LAT));
    read_event("R6 kept event", 1, 1'b0);
  endtask

  task automatic t_stale_trig;
    bx_i = 8'd60;
    pulse_pix(100, 101);
    idle(3);
    bx_i = 8'd61;
    pulse_pix(5, 5);
    idle(5);
    exp_pix[0] = 5;
    trigger(8'(61 + LAT));
    read_event("R7 stale skipped", 1, 1'b0);
  endtask

  task automatic t_age_purge;
    bx_i = 8'd70;
    pulse_pix(42, 43);
    idle(5);
    bx_i = 8'(70 + LAT + 1);
    idle(10);
    trigger(8'(70 + LAT));
    expect_silent("R8 purged without trigger", 20);
  endtask

  task automatic t_overflow;
    bx_i = 8'd100;
    for (int k = 0; k < 12; k++) begin
      pulse_pix(k, k);
      idle(2);
    end
    check("R9 no loss yet", int'(evt_lost_cnt_o), 0);
    pulse_pix(50, 50);
    idle(3);
    check("R9 ts full event lost", int'(evt_lost_cnt_o), 1);
    exp_pix[0] = 0;
    trigger(8'(100 + LAT));
    read_event("R9 oldest kept", 1, 1'b0);
    bx_i = 8'(100 + LAT + 1);
    idle(60);
    bx_i = 8'd0;
    pulse_pix(0, 32);
    idle(40);
    check("R10 hit lost", int'(hit_lost_cnt_o), 1);
    check("R10 evt unchanged", int'(evt_lost_cnt_o), 1);
    pulse_pix(40, 40);
    idle(3);
    check("R9 data full event lost", int'(evt_lost_cnt_o), 2);
    for (int i = 0; i < 32; i++) exp_pix[i] = i;
    trigger(8'(LAT));
    read_event("R10 partial event", 32, 1'b0);
  endtask

  initial begin
    for (int p = 0; p < NP; p++) amp_i[p*8 +: 8] = amp_of(p);
    idle(3);
    t_reset;
    rst_ni = 1'b1;
    idle(2);
    t_reset;
    t_basic_and_rehit;
    t_split;
    t_young;
    t_stale_trig;
    t_age_purge;
    t_overflow;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule